// File: doc/BRIEF.md
# RS-485 Auto Direction Controller

This block sits beside a UART transmitter and drives the enable of a half-duplex RS-485 line driver through the RTS pin. When the feature is on, any write into the transmit FIFO puts the line into its transmitting state at once. The block returns the line to receive only after the transmitter has gone fully quiet, with an empty FIFO and an empty shift register, and then one further bit time, counted in baud-generator ticks, has passed. This covers the final stop bit on the wire.

The block also produces the transmit-empty interrupt request. With the feature off, the request follows the holding side: it is raised as soon as the FIFO is empty, even while the shift register is still sending. With the feature on, the request also waits for the shift register to finish. A polarity input inverts the direction level. When the feature is off, the pin carries the ordinary modem-control RTS bit.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: After reset with `auto_en` high and no FIFO write, `rts_out` is at the receive level, which is `1 ^ invert`.
- R2: While `auto_en` is low, `rts_out` equals `mcr_rts`.
- R3: While `auto_en` is low, `tx_irq` equals `fifo_empty`, whatever the value of `tsr_empty`.
- R4: While `auto_en` is high, `tx_irq` is high only when both `fifo_empty` and `tsr_empty` are high.
- R5: With `auto_en` high, a `fifo_wr` pulse puts `rts_out` at the transmit level `invert` from the next clock cycle.
- R6: When `fifo_empty` and `tsr_empty` are both high and no write occurs, `rts_out` keeps the transmit level through `TICKS_PER_BIT-1` baud ticks. It changes to the receive level in the cycle after the `TICKS_PER_BIT`-th tick.
- R7: A `fifo_wr` during that hold window cancels the count. The line stays at the transmit level, and a full new window is needed once the transmitter is empty again.
- R8: Baud ticks that arrive while the FIFO holds data or the shift register is busy do not advance the release count.
- R9: Setting `invert` swaps the transmit and receive levels of `rts_out`.
- R10: Clearing `auto_en` drops any pending transmit state. When the feature is enabled again, the line starts at the receive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| auto_en | input | 1 | Enables automatic direction control |
| invert | input | 1 | Inverts the direction output level |
| mcr_rts | input | 1 | Modem-control RTS bit, used when the feature is off |
| fifo_wr | input | 1 | Strobe for a byte written into the transmit FIFO |
| fifo_empty | input | 1 | Transmit FIFO (holding side) is empty |
| tsr_empty | input | 1 | Transmit shift register has finished its stop bit |
| baud_tick | input | 1 | 16x oversampling tick from the baud generator |
| rts_out | output | 1 | Direction / RTS pin |
| tx_irq | output | 1 | Transmit-empty interrupt request |

## Verification
The only internal state is a driving flag and a tick counter, so a fault in either shows on `rts_out`. A flag stuck active or released early is visible within one clock of a write, or at the 16th tick of the hold window. A counter that fails to clear, whether after a cancelling write or during busy ticks, makes the release arrive too early. That error is caught by sampling `rts_out` after exactly 15 and exactly 16 idle ticks, for more than one character length.

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic auto_en,
  input  logic invert,
  input  logic mcr_rts,
  input  logic fifo_wr,
  input  logic fifo_empty,
  input  logic tsr_empty,
  input  logic baud_tick,
  output logic rts_out,
  output logic tx_irq
);
  localparam int CW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_BIT - 1);

  logic          driving;
  logic [CW-1:0] cnt;
  logic          quiet;

  assign quiet = fifo_empty & tsr_empty & ~fifo_wr;

  always_ff @(posedge clk) begin
    if (!rst_n || !auto_en) begin
      driving <= 1'b0;
      cnt     <= '0;
    end else if (fifo_wr) begin
      driving <= 1'b1;
      cnt     <= '0;
    end else if (driving && quiet) begin
      if (baud_tick) begin
        if (cnt == LAST) begin
          driving <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else begin
      cnt <= '0;
    end
  end

  assign rts_out = auto_en ? (~driving ^ invert) : mcr_rts;
  assign tx_irq  = fifo_empty & (tsr_empty | ~auto_en);
endmodule

module rs485_dir_chk (
  input logic clk,
  input logic rst_n,
  input logic auto_en,
  input logic invert,
  input logic mcr_rts,
  input logic fifo_wr,
  input logic fifo_empty,
  input logic tsr_empty,
  input logic baud_tick,
  input logic rts_out,
  input logic tx_irq
);
  // R5
  wr_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && fifo_wr) |=> (!auto_en || !$stable(invert) || rts_out == invert));

  // R6
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && rts_out == invert && !baud_tick) |=>
      (!auto_en || !$stable(invert) || rts_out == invert));

  // R8
  busy_keeps_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && rts_out == invert && !(fifo_empty && tsr_empty)) |=>
      (!auto_en || !$stable(invert) || rts_out == invert));

  // R4
  irq_waits_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_en && tx_irq) |-> (fifo_empty && tsr_empty));

  // R3
  irq_holding_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && fifo_empty && !tsr_empty) |-> tx_irq);
endmodule

bind rs485_dir_ctrl rs485_dir_chk chk (.*);

// File: tb/tb_rs485_dir_ctrl.sv
module tb_rs485_dir_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TPB = 16;

  logic clk = 1'b0;
  logic rst_n, auto_en, invert, mcr_rts, fifo_wr, fifo_empty, tsr_empty, baud_tick;
  logic rts_out, tx_irq;
  int checks = 0, errors = 0;

  rs485_dir_ctrl #(.TICKS_PER_BIT(TPB)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // {auto_en, mcr_rts, fifo_empty, tsr_empty, exp_irq, exp_rts}, idle line, invert=0
  localparam logic [5:0] VEC [8] = '{
    6'b001010, 6'b011111, 6'b000000, 6'b010101,
    6'b101111, 6'b101001, 6'b100101, 6'b110001};

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic tick();
    baud_tick = 1'b1; cyc(); baud_tick = 1'b0; cyc();
  endtask

  // load one character and shift start + data + stop bits
  task automatic frame(int dbits, string req);
    fifo_wr = 1'b1; fifo_empty = 1'b0; cyc();
    fifo_wr = 1'b0;
    check(req, rts_out, invert);
    fifo_empty = 1'b1; tsr_empty = 1'b0; cyc();
    check("R4", tx_irq, 1'b0);
    for (int i = 0; i < (dbits + 2) * TPB; i++) tick();
    check(req, rts_out, invert);
    tsr_empty = 1'b1; cyc();
    check("R4", tx_irq, 1'b1);
  endtask

  task automatic hold_release(string req);
    for (int i = 0; i < TPB - 1; i++) tick();
    check(req, rts_out, invert);
    tick();
    check(req, rts_out, ~invert);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; auto_en = 1'b1; invert = 1'b0; mcr_rts = 1'b0;
    fifo_wr = 1'b0; fifo_empty = 1'b1; tsr_empty = 1'b1; baud_tick = 1'b0;
    cyc(); cyc(); rst_n = 1'b1; cyc();
    check("R1", rts_out, 1'b1);

    foreach (VEC[i]) begin
      {auto_en, mcr_rts, fifo_empty, tsr_empty} = VEC[i][5:2];
      cyc();
      check(VEC[i][5] ? "R4" : "R3", tx_irq, VEC[i][1]);
      check(VEC[i][5] ? "R1" : "R2", rts_out, VEC[i][0]);
    end

    auto_en = 1'b1; mcr_rts = 1'b0; fifo_empty = 1'b1; tsr_empty = 1'b1; cyc();

    frame(8, "R5"); hold_release("R6");
    frame(5, "R5"); hold_release("R6");

    // R7: cancel mid-hold
    frame(6, "R5");
    for (int i = 0; i < 10; i++) tick();
    check("R7", rts_out, 1'b0);
    frame(5, "R7");
    hold_release("R7");

    // R8: ticks while FIFO holds data do not count
    fifo_wr = 1'b1; fifo_empty = 1'b0; cyc(); fifo_wr = 1'b0;
    for (int i = 0; i < TPB + 4; i++) tick();
    check("R8", rts_out, 1'b0);
    fifo_empty = 1'b1; tsr_empty = 1'b0;
    for (int i = 0; i < TPB + 4; i++) tick();
    check("R8", rts_out, 1'b0);
    tsr_empty = 1'b1; cyc();
    hold_release("R8");

    // R9: inverted polarity
    invert = 1'b1; cyc();
    check("R9", rts_out, 1'b0);
    frame(7, "R9"); hold_release("R9");

    // R10: disable mid-transmission
    invert = 1'b0;
    frame(8, "R10");
    for (int i = 0; i < 4; i++) tick();
    auto_en = 1'b0; mcr_rts = 1'b1; cyc();
    check("R2", rts_out, 1'b1);
    mcr_rts = 1'b0; cyc();
    check("R2", rts_out, 1'b0);
    auto_en = 1'b1; cyc();
    check("R10", rts_out, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule